// File: doc/BRIEF.md
# One-Time-Programmable Parameter Store with Volatile Shadow

This block keeps the configuration parameters of a sensing device in two banks of sixteen 16-bit registers. The first bank is set-once storage: each bit of a register can be burned only once and the contents survive power cycles. The second is an ordinary register bank that mirrors the first and drives normal operation. The one-time bank is modelled as a register array that keeps its contents through reset and can only ever be written through the program command.

Software reaches both banks through one port. It has an address, write data, a write strobe, a program strobe and combinational read data. Software first writes a parameter into the shadow bank and reads it back to confirm it. It then issues a program command on that register, which burns the shadow value into the one-time bank with the inhibit flag set. While the reset input is held low, the block loads the shadow bank from the one-time bank. The chip-identity region is not copied.

A volatile-mode input lets already programmed parameters be overridden in the shadow bank for development. A busy flag covers the fixed burn time after each program command.

Top module: `otp_param_store`

## Requirements
- R1: Read data is combinational. Address n in 0–15 returns one-time register n, and address 16+n returns shadow register n.
- R2: On every rising clock edge while `rstN` is low, shadow registers 0–7 load the value of the matching one-time register and shadow registers 8–15 clear to zero. The one-time bank keeps its contents through reset.
- R3: The factory image holds zero in registers 0–3 and 7. Register n in 4–6 holds 0x8000 | ((SEED ^ n*0x0111) & 0x7FFF), and register n in 8–15 holds 0x8000 | ((SEED + n*0x1357) & 0x7FFF). The default SEED is 0x5A3C.
- R4: A write to shadow address 16+n with n in {0,1,2,3,7} stores the write data, and it reads back after the next clock edge, provided R5, R8 and R10 do not block it.
- R5: Bit 15 of one-time register n is its inhibit flag. While that flag is 1, writes to shadow register n are ignored unless `vmodeEn` is 1.
- R6: A program command at address n or 16+n, with n in {0,1,2,3,7}, writes shadow register n OR 0x8000 into one-time register n, but only if that register's bit 15 is 0. Otherwise the command is ignored, so a programmed register never changes again.
- R7: `busy` is 1 for exactly BUSY_CYCLES (default 8) clock cycles after the edge that accepts a program command, and 0 otherwise (including right after reset).
- R8: While `busy` is 1, writes and program commands are ignored. When `wrEn` and `progEn` arrive together, the program command is taken and the write is dropped.
- R9: Writes to addresses 0–15, and to the shadow registers of indices 4–6 and 8–15, change no register.
- R10: Addresses 32 and above read as zero, and writes or program commands to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; performs the boot copy |
| vmodeEn | input | 1 | Volatile mode: allows shadow writes past the inhibit flag |
| addr | input | ADDR_W (6) | Register address |
| wrData | input | 16 | Write data |
| wrEn | input | 1 | Write strobe, one cycle per write |
| progEn | input | 1 | Program command strobe for the addressed register |
| rdData | output | 16 | Combinational read data |
| busy | output | 1 | Program burn in progress |

## Verification
The assertions take for granted that reset is held low from time zero across at least one clock edge, so the inhibit history and the busy counter start from known values. They also assume that the strobes and the address change only away from the rising edge. The stimulus drives every input just after a falling edge and holds reset low for three cycles at the start. All addresses come from the defined 6-bit space, so the reserved-address checks see only legal values.

// File: rtl/otp_store_pkg.sv
package otp_store_pkg;
  localparam int REG_W = 16;
  localparam int REG_N = 16;
  localparam int IDX_W = $clog2(REG_N);

  typedef struct packed {
    logic             shWr;
    logic             otpProg;
    logic [IDX_W-1:0] idx;
  } ctrlStrobe_t;

  function automatic logic isUserReg(input logic [IDX_W-1:0] i);
    return (i <= IDX_W'(3)) || (i == IDX_W'(7));
  endfunction

  function automatic logic isChipId(input logic [IDX_W-1:0] i);
    return i[IDX_W-1];
  endfunction

  function automatic logic [REG_W-1:0] factoryWord(input logic [REG_W-1:0] seed,
                                                   input logic [IDX_W-1:0] i);
    logic [REG_W-1:0] wi;
    wi = REG_W'(i);
    if (isUserReg(i)) return '0;
    if (isChipId(i)) return 16'h8000 | ((seed + wi * 16'h1357) & 16'h7FFF);
    return 16'h8000 | ((seed ^ (wi * 16'h0111)) & 16'h7FFF);
  endfunction
endpackage

// File: rtl/otp_store_ctrl.sv
module otp_store_ctrl
  import otp_store_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int BUSY_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vmodeEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              progEn,
  input  logic [REG_N-1:0]  inhibit,
  output ctrlStrobe_t       strobe,
  output logic              busy
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] busyCnt;
  logic [IDX_W-1:0] idx;
  logic             inBank, isShadow, progOk, wrOk;

  assign idx      = addr[IDX_W-1:0];
  assign inBank   = (addr >> (IDX_W + 1)) == '0;
  assign isShadow = inBank && addr[IDX_W];
  assign busy     = busyCnt != '0;

  // A program command beats a write in the same cycle (R8).
  assign progOk = rstN && progEn && !busy && inBank && isUserReg(idx) && !inhibit[idx];
  assign wrOk   = rstN && wrEn && !progEn && !busy && isShadow && isUserReg(idx)
                  && (!inhibit[idx] || vmodeEn);

  always_comb begin
    strobe.shWr    = wrOk;
    strobe.otpProg = progOk;
    strobe.idx     = idx;
  end

  always_ff @(posedge clk) begin
    if (!rstN)       busyCnt <= '0;
    else if (progOk) busyCnt <= CNT_W'(BUSY_CYCLES);
    else if (busy)   busyCnt <= busyCnt - 1'b1;
  end
endmodule

// File: rtl/otp_store_datapath.sv
module otp_store_datapath
  import otp_store_pkg::*;
#(
  parameter int              ADDR_W = 6,
  parameter logic [REG_W-1:0] SEED  = 16'h5A3C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  input  ctrlStrobe_t       strobe,
  output logic [REG_N-1:0]  inhibit,
  output logic [REG_W-1:0]  rdData
);
  logic [REG_W-1:0] otpMem [REG_N];
  logic [REG_W-1:0] shadowMem [REG_N];
  logic [IDX_W-1:0] rdIdx;

  // Factory image of the set-once bank; it is never reset afterwards.
  initial begin
    for (int i = 0; i < REG_N; i++) otpMem[i] = factoryWord(SEED, IDX_W'(i));
  end

  always_ff @(posedge clk) begin
    if (strobe.otpProg) otpMem[strobe.idx] <= shadowMem[strobe.idx] | 16'h8000;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REG_N; i++)
        shadowMem[i] <= isChipId(IDX_W'(i)) ? '0 : otpMem[i];
    end else if (strobe.shWr) begin
      shadowMem[strobe.idx] <= wrData;
    end
  end

  generate
    for (genvar g = 0; g < REG_N; g++) begin : g_inh
      assign inhibit[g] = otpMem[g][REG_W-1];
    end
  endgenerate

  assign rdIdx = addr[IDX_W-1:0];

  always_comb begin
    if ((addr >> (IDX_W + 1)) != '0) rdData = '0;
    else if (addr[IDX_W])             rdData = shadowMem[rdIdx];
    else                              rdData = otpMem[rdIdx];
  end
endmodule

// File: rtl/otp_param_store.sv
module otp_param_store
  import otp_store_pkg::*;
#(
  parameter int              ADDR_W      = 6,
  parameter int              BUSY_CYCLES = 8,
  parameter logic [REG_W-1:0] SEED       = 16'h5A3C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vmodeEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  input  logic              wrEn,
  input  logic              progEn,
  output logic [REG_W-1:0]  rdData,
  output logic              busy
);
  ctrlStrobe_t      strobe;
  logic [REG_N-1:0] inhibit;

  otp_store_ctrl #(.ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .vmodeEn(vmodeEn), .addr(addr), .wrEn(wrEn),
    .progEn(progEn), .inhibit(inhibit), .strobe(strobe), .busy(busy)
  );

  otp_store_datapath #(.ADDR_W(ADDR_W), .SEED(SEED)) u_dp (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .strobe(strobe),
    .inhibit(inhibit), .rdData(rdData)
  );
endmodule

// File: rtl/otp_store_checker.sv
module otp_store_checker
  import otp_store_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic [REG_W-1:0]  rdData,
  input logic              busy,
  input ctrlStrobe_t       strobe,
  input logic [REG_N-1:0]  inhibit
);
  // R6: an inhibit fuse once burned never clears.
  a_r6_fuse_sticky: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(inhibit) & ~inhibit) == '0));

  // R7: an accepted program command raises busy at the next cycle.
  a_r7_busy_after_prog: assert property (@(posedge clk) disable iff (!rstN)
    strobe.otpProg |=> busy);

  // R8: no register update is issued while busy.
  a_r8_quiet_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(strobe.shWr || strobe.otpProg));

  // R8: write and program are never issued in the same cycle.
  a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.shWr, strobe.otpProg}));

  // R10: reserved addresses read as zero.
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    ((addr >> (IDX_W + 1)) != '0) |-> (rdData == '0));

  // R6: a program command only touches a register whose fuse is still clear.
  a_r6_prog_unburned: assert property (@(posedge clk) disable iff (!rstN)
    strobe.otpProg |-> !inhibit[strobe.idx]);
endmodule

bind otp_param_store otp_store_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .rdData(rdData), .busy(busy),
  .strobe(strobe), .inhibit(inhibit)
);

// File: tb/sim_otp_param_store.sv
module sim_otp_param_store;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY_N = 8;
  localparam logic [15:0] SEED = 16'h5A3C;

  logic clk = 1'b0, rstN = 1'b0, vmodeEn = 1'b0, wrEn = 1'b0, progEn = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wrData = '0, rdData;
  logic busy;
  int checks = 0, fails = 0, cycles = 0;

  otp_param_store #(.ADDR_W(6), .BUSY_CYCLES(BUSY_N), .SEED(SEED)) u0 (
    .clk(clk), .rstN(rstN), .vmodeEn(vmodeEn), .addr(addr), .wrData(wrData),
    .wrEn(wrEn), .progEn(progEn), .rdData(rdData), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycles++;

  initial begin
    wait (cycles > 200000);
    fails++;
    $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 200000", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // Expected factory image, written from the R3 formula.
  function automatic logic [15:0] benchFactory(input int n);
    if (n <= 3 || n == 7) return 16'h0000;
    if (n >= 8) return 16'h8000 | ((SEED + 16'(n) * 16'h1357) & 16'h7FFF);
    return 16'h8000 | ((SEED ^ (16'(n) * 16'h0111)) & 16'h7FFF);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic readAt(input logic [5:0] a, input string req, input logic [15:0] exp);
    addr = a;
    #1;
    check(req, rdData, exp);
  endtask

  // op: 0 read-check, 1 write, 2 program, 3 idle cycles (count in data)
  typedef struct packed {
    logic [1:0]  op;
    logic [5:0]  addr;
    logic [15:0] data;
    logic        vm;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 6'd16, 16'h1234, 1'b0, 4'd4},  // R4 write user reg 0
    '{2'd0, 6'd16, 16'h1234, 1'b0, 4'd4},
    '{2'd1, 6'd17, 16'hFFFF, 1'b0, 4'd4},
    '{2'd0, 6'd17, 16'hFFFF, 1'b0, 4'd4},
    '{2'd1, 6'd3,  16'hAAAA, 1'b0, 4'd9},  // R9 direct one-time write ignored
    '{2'd0, 6'd3,  16'h0000, 1'b0, 4'd9},
    '{2'd1, 6'd23, 16'h0042, 1'b0, 4'd4},  // device address shadow
    '{2'd0, 6'd23, 16'h0042, 1'b0, 4'd4},
    '{2'd2, 6'd16, 16'h0000, 1'b0, 4'd6},  // R6 burn reg 0
    '{2'd1, 6'd17, 16'h1111, 1'b0, 4'd8},  // R8 write while busy
    '{2'd0, 6'd17, 16'hFFFF, 1'b0, 4'd8},
    '{2'd0, 6'd0,  16'h9234, 1'b0, 4'd6},
    '{2'd3, 6'd0,  16'd8,    1'b0, 4'd7},
    '{2'd1, 6'd16, 16'h5555, 1'b0, 4'd5},  // R5 inhibited
    '{2'd0, 6'd16, 16'h1234, 1'b0, 4'd5},
    '{2'd1, 6'd16, 16'h5555, 1'b1, 4'd5},  // R5 volatile mode override
    '{2'd0, 6'd16, 16'h5555, 1'b0, 4'd5},
    '{2'd2, 6'd16, 16'h0000, 1'b0, 4'd6},  // R6 second burn ignored
    '{2'd0, 6'd0,  16'h9234, 1'b0, 4'd6},
    '{2'd2, 6'd1,  16'h0000, 1'b0, 4'd6},  // R6 burn by one-time address
    '{2'd3, 6'd0,  16'd8,    1'b0, 4'd7},
    '{2'd0, 6'd1,  16'hFFFF, 1'b0, 4'd6},
    '{2'd1, 6'd40, 16'hBEEF, 1'b0, 4'd10}  // R10 reserved write
  };

  initial begin
    @(negedge clk);
    tick(); tick(); tick();
    // Reset state, boot copy and factory image (R2, R3, R7, R1)
    check("R7 busy after reset", {15'd0, busy}, 16'h0000);
    readAt(6'd4,  "R3 trim reg 4",   benchFactory(4));
    readAt(6'd6,  "R3 trim reg 6",   benchFactory(6));
    readAt(6'd8,  "R3 chip id 8",    benchFactory(8));
    readAt(6'd15, "R3 chip id 15",   benchFactory(15));
    readAt(6'd20, "R2 trim copied",  benchFactory(4));
    readAt(6'd24, "R2 id not copied", 16'h0000);
    readAt(6'd16, "R1 shadow 0",     16'h0000);
    rstN = 1'b1;
    tick();

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vector %0d", VECS[i].req, i);
      addr = VECS[i].addr;
      vmodeEn = VECS[i].vm;
      case (VECS[i].op)
        2'd0: begin #1; check(tag, rdData, VECS[i].data); end
        2'd1: begin wrData = VECS[i].data; wrEn = 1'b1; tick(); wrEn = 1'b0; end
        2'd2: begin progEn = 1'b1; tick(); progEn = 1'b0; end
        default: for (int k = 0; k < int'(VECS[i].data); k++) tick();
      endcase
      vmodeEn = 1'b0;
    end
    readAt(6'd40, "R10 reserved reads zero", 16'h0000);
    readAt(6'd63, "R10 top address zero", 16'h0000);

    // R9: trim shadow write ignored
    addr = 6'd20; wrData = 16'h0123; vmodeEn = 1'b1; wrEn = 1'b1; tick();
    wrEn = 1'b0; vmodeEn = 1'b0;
    readAt(6'd20, "R9 trim shadow write", benchFactory(4));

    // R7: busy window length after burning reg 7
    addr = 6'd23; progEn = 1'b1; tick(); progEn = 1'b0;
    check("R7 busy first cycle", {15'd0, busy}, 16'h0001);
    for (int k = 1; k < BUSY_N; k++) tick();
    check("R7 busy last cycle", {15'd0, busy}, 16'h0001);
    tick();
    check("R7 busy cleared", {15'd0, busy}, 16'h0000);
    readAt(6'd7, "R6 reg 7 burned", 16'h8042);

    // R2: second reset reloads shadow from the persisting one-time bank
    addr = 6'd24; rstN = 1'b0; tick(); tick(); rstN = 1'b1;
    readAt(6'd16, "R2 reload reg 0", 16'h9234);
    readAt(6'd17, "R2 reload reg 1", 16'hFFFF);
    readAt(6'd23, "R2 reload reg 7", 16'h8042);
    readAt(6'd24, "R2 id shadow cleared", 16'h0000);

    // R8: program and write together, program wins
    addr = 6'd18; wrData = 16'h0BAD; wrEn = 1'b1; progEn = 1'b1; tick();
    wrEn = 1'b0; progEn = 1'b0;
    readAt(6'd18, "R8 write dropped", 16'h0000);
    readAt(6'd2,  "R8 program taken", 16'h8000);
    for (int k = 0; k < BUSY_N; k++) tick();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule